// File: doc/BRIEF.md
# SMBus Indexed Register Target

This block is an SMBus target that holds a small bank of byte-wide configuration registers for a clocking subsystem. A host writes a run of registers by naming a starting index and a byte count, then streaming the data. It reads them back by naming an index, issuing a repeated START and the read address. The target answers with the count first and then the register contents in index order.

The block runs entirely on the system clock. It oversamples SCL and SDA through a synchronizer and finds START and STOP conditions from SDA edges while SCL is high. It pulls SDA low through an open-drain enable. Every register is also presented on a parallel output bus so that neighbouring logic can use the settings directly.

Three straps are captured into read-only bits when reset is applied. Identity bytes are fixed. A factory test byte is shielded from writes entirely.

Top module: `smb_cfg_regbank`

## Requirements
- R1: The target acknowledges the address byte 0xD2 (7-bit address 0x69 with write) and 0xD3 (read). Any other address byte is not acknowledged, and the target then leaves every following byte unacknowledged and unused until the next START.
- R2: After reset, registers 0 to 3 read 0xFF, register 8 reads 0x08, and every writable register outside those reads 0x00.
- R3: A write carries four parts in this order: address, starting index N, count X, then X data bytes. The data bytes land in registers N, N+1 and so on, each acknowledged. A data byte beyond X is not acknowledged and is dropped. A starting index of 22 or more is not acknowledged.
- R4: Register 9 always reads 0x0B and register 7 always reads 0x01. Bits 2:0 of register 6 hold the strap inputs captured during reset, and later strap changes do not reach them. Writes leave all of these bits unchanged, while bits 7:3 of register 6 are writable.
- R5: A write to register 21 is acknowledged but leaves it at 0x00.
- R6: After a read address, the target first sends the value of register 8. It then sends that many data bytes starting at the current index. Any further byte the host requests is 0xFF, with SDA released.
- R7: The register index advances by one per data byte and wraps from 21 to 0, on both writes and reads.
- R8: A START or STOP in the middle of a byte abandons the transfer. Bytes completed before it keep their effect, and a new transaction after it works normally.
- R9: SDA is driven only low, and the drive enable changes only after a falling SCL edge or at a START or STOP. The enable is released on STOP.
- R10: Register k appears on cfg_regs[8k+7:8k]. A written value appears there a few system clocks after the falling SCL edge that ends the byte's eighth bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; captures the straps |
| scl_in | input | 1 | SMBus clock line as seen at the pad |
| sda_in | input | 1 | SMBus data line as seen at the pad |
| strap_fs | input | 3 | Frequency-select strap levels |
| sda_oe | output | 1 | Pull SDA low when 1 |
| cfg_regs | output | 176 | All 22 registers, register k at bits 8k+7:8k |

## Verification
The bench aims at the edges of the count and the index. A design that ignored the count would accept a byte past X, and a design that did not wrap would write past register 21 and miss register 0. Read-back is checked from the count byte through the filler 0xFF after a shortened count. A target that sent data before the count, or kept streaming registers, would fail here. Writes to identity, strap and test bits, a foreign address followed by stray bytes, and START and STOP dropped in mid-byte are also covered. A target that let protected bits move, answered for another address, or resumed a broken transfer would show a changed register or a wrong acknowledge.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    localparam int NUM_REGS = 22;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int STRAP_W  = 3;

    localparam logic [IDX_W-1:0] STRAP_IDX  = IDX_W'(6);
    localparam logic [IDX_W-1:0] VENDOR_IDX = IDX_W'(7);
    localparam logic [IDX_W-1:0] COUNT_IDX  = IDX_W'(8);
    localparam logic [IDX_W-1:0] DEVID_IDX  = IDX_W'(9);
    localparam logic [IDX_W-1:0] TEST_IDX   = IDX_W'(21);
    localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(NUM_REGS - 1);
    localparam logic [7:0]       NUM_REGS_B = 8'(NUM_REGS);

    typedef enum logic [2:0] {
        L_IDLE, L_RX, L_ACK_OUT, L_TX, L_ACK_IN, L_IGNORE
    } link_state_e;

    typedef enum logic [1:0] {
        P_ADDR, P_INDEX, P_COUNT, P_DATA
    } rx_phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    // Bits a host may change in a register
    function automatic logic [7:0] wr_mask(input logic [IDX_W-1:0] idx);
        if (idx == VENDOR_IDX || idx == DEVID_IDX || idx == TEST_IDX)
            return 8'h00;
        else if (idx == STRAP_IDX)
            return 8'hF8;
        else
            return 8'hFF;
    endfunction

    // Value after reset, excluding strap bits
    function automatic logic [7:0] base_value(input logic [IDX_W-1:0] idx);
        if (idx <= IDX_W'(3))      return 8'hFF;
        else if (idx == VENDOR_IDX) return 8'h01;
        else if (idx == COUNT_IDX)  return 8'h08;
        else if (idx == DEVID_IDX)  return 8'h0B;
        else                        return 8'h00;
    endfunction

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
        return (i == LAST_IDX) ? '0 : i + 1'b1;
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_cfg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    localparam int LANES = 2;

    logic [LANES-1:0] raw;
    logic [LANES-1:0] synced;
    logic [LANES-1:0] prev;

    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    // lane 1 is SCL, lane 0 is SDA
    always_comb begin
        evt.start    = synced[1] & prev[1] & prev[0] & ~synced[0];
        evt.stop     = synced[1] & prev[1] & ~prev[0] & synced[0];
        evt.scl_rise = synced[1] & ~prev[1];
        evt.scl_fall = ~synced[1] & prev[1];
        evt.sda      = synced[0];
    end
endmodule

// File: rtl/smb_reg_file.sv
module smb_reg_file
    import smb_cfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [STRAP_W-1:0]    strap,
    input  logic                  we,
    input  logic [IDX_W-1:0]      waddr,
    input  logic [7:0]            wdata,
    input  logic [IDX_W-1:0]      raddr,
    output logic [7:0]            rdata,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        localparam logic [IDX_W-1:0] KI = IDX_W'(k);
        localparam logic [7:0]       KM = wr_mask(KI);
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= base_value(KI) | ((KI == STRAP_IDX) ? 8'(strap) : 8'h00);
            else if (we && waddr == KI)
                q <= (q & ~KM) | (wdata & KM);
        end
        assign regs_flat[k*8 +: 8] = q;
    end

    always_comb begin
        rdata = 8'h00;
        for (int k = 0; k < NUM_REGS; k++)
            if (raddr == IDX_W'(k)) rdata = regs_flat[k*8 +: 8];
    end
endmodule

// File: rtl/smb_link_ctrl.sv
module smb_link_ctrl
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h69
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_evt_t         evt,
    input  logic [7:0]       rd_byte,
    input  logic [7:0]       count_val,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic [IDX_W-1:0] ptr
);
    link_state_e state;
    rx_phase_e   phase;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg;
    logic [7:0]  txreg;
    logic [7:0]  wr_left;
    logic [7:0]  rd_left;
    logic        rd_mode;
    logic        host_ack;

    assign sda_oe = (state == L_ACK_OUT) | ((state == L_TX) & ~txreg[7]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= L_IDLE;
            phase    <= P_ADDR;
            bitcnt   <= '0;
            shreg    <= '0;
            txreg    <= 8'hFF;
            wr_left  <= '0;
            rd_left  <= '0;
            rd_mode  <= 1'b0;
            host_ack <= 1'b0;
            ptr      <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (evt.start) begin
                state  <= L_RX;
                phase  <= P_ADDR;
                bitcnt <= '0;
            end else if (evt.stop) begin
                state <= L_IDLE;
            end else begin
                case (state)
                    L_RX: begin
                        if (evt.scl_rise) begin
                            shreg  <= {shreg[6:0], evt.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (evt.scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            state  <= L_IGNORE;
                            case (phase)
                                P_ADDR: if (shreg[7:1] == TARGET_ADDR) begin
                                    state   <= L_ACK_OUT;
                                    rd_mode <= shreg[0];
                                    phase   <= P_INDEX;
                                end
                                P_INDEX: if (shreg < NUM_REGS_B) begin
                                    state <= L_ACK_OUT;
                                    ptr   <= shreg[IDX_W-1:0];
                                    phase <= P_COUNT;
                                end
                                P_COUNT: begin
                                    state   <= L_ACK_OUT;
                                    wr_left <= shreg;
                                    phase   <= P_DATA;
                                end
                                default: if (wr_left != 8'd0) begin
                                    state   <= L_ACK_OUT;
                                    wr_en   <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= shreg;
                                    ptr     <= next_idx(ptr);
                                    wr_left <= wr_left - 1'b1;
                                end
                            endcase
                        end
                    end
                    L_ACK_OUT: if (evt.scl_fall) begin
                        bitcnt <= '0;
                        if (rd_mode) begin
                            txreg   <= count_val;
                            rd_left <= count_val;
                            state   <= L_TX;
                        end else begin
                            state <= L_RX;
                        end
                    end
                    L_TX: if (evt.scl_fall) begin
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == 4'd7) begin
                            txreg <= 8'hFF;
                            state <= L_ACK_IN;
                        end else begin
                            txreg <= {txreg[6:0], 1'b1};
                        end
                    end
                    L_ACK_IN: begin
                        if (evt.scl_rise) begin
                            host_ack <= ~evt.sda;
                        end else if (evt.scl_fall) begin
                            bitcnt <= '0;
                            if (host_ack) begin
                                state <= L_TX;
                                if (rd_left != 8'd0) begin
                                    txreg   <= rd_byte;
                                    ptr     <= next_idx(ptr);
                                    rd_left <= rd_left - 1'b1;
                                end else begin
                                    txreg <= 8'hFF;
                                end
                            end else begin
                                state <= L_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_cfg_regbank.sv
module smb_cfg_regbank
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h69,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_in,
    input  logic                  sda_in,
    input  logic [STRAP_W-1:0]    strap_fs,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_regs
);
    bus_evt_t         evt;
    logic             wr_en;
    logic [IDX_W-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic [IDX_W-1:0] ptr;
    logic [7:0]       rd_byte;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    smb_link_ctrl #(.TARGET_ADDR(TARGET_ADDR)) u_link (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .rd_byte   (rd_byte),
        .count_val (cfg_regs[COUNT_IDX*8 +: 8]),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ptr       (ptr)
    );

    smb_reg_file u_regs (
        .clk       (clk),
        .rst       (rst),
        .strap     (strap_fs),
        .we        (wr_en),
        .waddr     (wr_addr),
        .wdata     (wr_data),
        .raddr     (ptr),
        .rdata     (rd_byte),
        .regs_flat (cfg_regs)
    );
endmodule

// File: rtl/smb_cfg_regbank_chk.sv
module smb_cfg_regbank_chk
    import smb_cfg_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  sda_oe,
    input logic                  scl_fall,
    input logic                  start_seen,
    input logic                  stop_seen,
    input logic [NUM_REGS*8-1:0] cfg_regs
);
    // R2
    r2_reset_val_chk: assert property (@(posedge clk)
        rst |=> (cfg_regs[31:0] == 32'hFFFF_FFFF && cfg_regs[COUNT_IDX*8 +: 8] == 8'h08));

    // R4
    r4_ident_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_regs[DEVID_IDX*8 +: 8] == 8'h0B && cfg_regs[VENDOR_IDX*8 +: 8] == 8'h01);

    // R4
    r4_strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(cfg_regs[STRAP_IDX*8 +: STRAP_W]));

    // R5
    r5_test_byte_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_regs[TEST_IDX*8 +: 8] == 8'h00);

    // R9
    r9_release_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !sda_oe);

    // R9
    r9_drive_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(scl_fall));

    // R9
    r9_release_timing_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) |-> $past(scl_fall || start_seen || stop_seen));
endmodule

bind smb_cfg_regbank smb_cfg_regbank_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sda_oe     (sda_oe),
    .scl_fall   (evt.scl_fall),
    .start_seen (evt.start),
    .stop_seen  (evt.stop),
    .cfg_regs   (cfg_regs)
);

// File: tb/smb_cfg_regbank_bench.sv
`timescale 1ns/1ps
module smb_cfg_regbank_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         host_scl = 1'b1;
    logic         host_sda = 1'b1;
    logic [2:0]   strap = 3'b101;
    logic         sda_oe;
    logic [175:0] cfg_regs;
    wire          sda_bus = host_sda & ~sda_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] rx_data;
    event       rx_ev;

    always #4 clk = ~clk;

    smb_cfg_regbank u_smb_cfg_regbank (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (host_scl),
        .sda_in   (sda_bus),
        .strap_fs (strap),
        .sda_oe   (sda_oe),
        .cfg_regs (cfg_regs)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] rg(input int k);
        return cfg_regs[k*8 +: 8];
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        host_sda = 1'b1; tick(10);
        host_scl = 1'b1; tick(10);
        host_sda = 1'b0; tick(10);
        host_scl = 1'b0; tick(10);
    endtask

    task automatic bus_stop;
        host_sda = 1'b0; tick(10);
        host_scl = 1'b1; tick(10);
        host_sda = 1'b1; tick(20);
    endtask

    task automatic send_bit(input logic b);
        host_sda = b;    tick(10);
        host_scl = 1'b1; tick(20);
        host_scl = 1'b0; tick(10);
    endtask

    task automatic recv_bit(output logic b);
        host_sda = 1'b1; tick(10);
        host_scl = 1'b1; tick(10);
        b = sda_bus;     tick(10);
        host_scl = 1'b0; tick(10);
    endtask

    // send a byte and compare the target's acknowledge
    task automatic put(input string req, input logic [7:0] b, input logic exp_ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(a);
        check(req, !a, exp_ack);
    endtask

    // driver: push the expected byte, then clock it in
    task automatic get(input string req, input logic [7:0] exp, input logic ack_it);
        logic [7:0] b;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        for (int i = 7; i >= 0; i--) recv_bit(b[i]);
        rx_data = b;
        -> rx_ev;
        send_bit(!ack_it);
    endtask

    // monitor: compare each received byte with the scoreboard
    initial begin
        forever begin
            @(rx_ev);
            if (exp_q.size() == 0) begin
                check("R6 unexpected byte", rx_data, 32'hDEAD);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rx_data, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(6);
        rst = 1'b0;
        tick(10);
        // reset state
        check("R2 regs0-3", cfg_regs[31:0], 32'hFFFF_FFFF);
        check("R2 count reg", rg(8), 8'h08);
        check("R2 reg4", rg(4), 8'h00);
        check("R4 devid", rg(9), 8'h0B);
        check("R4 vendor", rg(7), 8'h01);
        check("R4 strap", rg(6), 8'h05);
        check("R9 idle release", sda_oe, 1'b0);
        strap = 3'b010;
        tick(10);
        check("R4 strap held", rg(6), 8'h05);

        // block write of three registers from index 4
        bus_start;
        put("R1 write addr", 8'hD2, 1);
        put("R3 index", 8'h04, 1);
        put("R3 count", 8'h03, 1);
        put("R3 data4", 8'hA5, 1);
        put("R3 data5", 8'h5A, 1);
        put("R4 data6", 8'h3C, 1);
        bus_stop;
        check("R10 reg4", rg(4), 8'hA5);
        check("R10 reg5", rg(5), 8'h5A);
        check("R4 reg6 masked", rg(6), 8'h3D);
        check("R9 released after stop", sda_oe, 1'b0);

        // block read from index 4 with default count
        bus_start;
        put("R1 write addr", 8'hD2, 1);
        put("R6 index", 8'h04, 1);
        bus_start;
        put("R1 read addr", 8'hD3, 1);
        get("R6 count first", 8'h08, 1);
        get("R6 reg4", 8'hA5, 1);
        get("R6 reg5", 8'h5A, 1);
        get("R6 reg6", 8'h3D, 1);
        get("R6 reg7", 8'h01, 1);
        get("R6 reg8", 8'h08, 1);
        get("R6 reg9", 8'h0B, 1);
        get("R6 reg10", 8'h00, 1);
        get("R6 reg11", 8'h00, 1);
        get("R6 filler", 8'hFF, 0);
        bus_stop;

        // read-only identity bytes
        bus_start;
        put("R1 write addr", 8'hD2, 1);
        put("R4 index9", 8'h09, 1);
        put("R4 count", 8'h01, 1);
        put("R4 data", 8'h55, 1);
        bus_stop;
        bus_start;
        put("R1 write addr", 8'hD2, 1);
        put("R4 index7", 8'h07, 1);
        put("R4 count", 8'h01, 1);
        put("R4 data", 8'hAA, 1);
        bus_stop;
        check("R4 devid kept", rg(9), 8'h0B);
        check("R4 vendor kept", rg(7), 8'h01);

        // wrap through the test byte
        bus_start;
        put("R1 write addr", 8'hD2, 1);
        put("R7 index20", 8'd20, 1);
        put("R7 count", 8'h03, 1);
        put("R7 data20", 8'h11, 1);
        put("R5 data21 acked", 8'h22, 1);
        put("R7 data0", 8'h33, 1);
        bus_stop;
        check("R7 reg20", rg(20), 8'h11);
        check("R5 reg21 kept", rg(21), 8'h00);
        check("R7 wrapped reg0", rg(0), 8'h33);

        // shorten the read-back count
        bus_start;
        put("R1 write addr", 8'hD2, 1);
        put("R6 index8", 8'h08, 1);
        put("R6 count", 8'h01, 1);
        put("R6 new count", 8'h03, 1);
        bus_stop;
        check("R6 count reg", rg(8), 8'h03);
        bus_start;
        put("R1 write addr", 8'hD2, 1);
        put("R7 index20", 8'd20, 1);
        bus_start;
        put("R1 read addr", 8'hD3, 1);
        get("R6 count first", 8'h03, 1);
        get("R7 read reg20", 8'h11, 1);
        get("R5 read reg21", 8'h00, 1);
        get("R7 read reg0", 8'h33, 1);
        get("R6 filler", 8'hFF, 1);
        get("R6 filler last", 8'hFF, 0);
        bus_stop;

        // bytes past the count
        bus_start;
        put("R1 write addr", 8'hD2, 1);
        put("R3 index10", 8'h0A, 1);
        put("R3 count", 8'h01, 1);
        put("R3 data10", 8'h77, 1);
        put("R3 extra byte", 8'h88, 0);
        bus_stop;
        check("R3 reg10", rg(10), 8'h77);
        check("R3 reg11 kept", rg(11), 8'h00);

        // index outside the bank
        bus_start;
        put("R1 write addr", 8'hD2, 1);
        put("R3 bad index", 8'h1E, 0);
        bus_stop;

        // foreign address, then stray bytes
        bus_start;
        put("R1 foreign write", 8'hA4, 0);
        put("R1 ignored byte", 8'h0A, 0);
        put("R1 ignored byte", 8'h01, 0);
        put("R1 ignored byte", 8'h99, 0);
        bus_stop;
        check("R1 reg10 kept", rg(10), 8'h77);
        bus_start;
        put("R1 foreign read", 8'hA5, 0);
        bus_stop;

        // STOP in mid-byte
        bus_start;
        put("R1 write addr", 8'hD2, 1);
        put("R8 index12", 8'h0C, 1);
        put("R8 count", 8'h02, 1);
        put("R8 data12", 8'h44, 1);
        send_bit(1); send_bit(0); send_bit(0); send_bit(1);
        bus_stop;
        check("R8 reg12", rg(12), 8'h44);
        check("R8 reg13 kept", rg(13), 8'h00);
        check("R9 released", sda_oe, 1'b0);

        // START in mid-byte, then a fresh write
        bus_start;
        put("R1 write addr", 8'hD2, 1);
        put("R8 index13", 8'h0D, 1);
        send_bit(0); send_bit(1); send_bit(1);
        bus_start;
        put("R8 write addr", 8'hD2, 1);
        put("R8 index13", 8'h0D, 1);
        put("R8 count", 8'h01, 1);
        put("R8 data13", 8'h66, 1);
        bus_stop;
        check("R8 reg13", rg(13), 8'h66);
        check("R2 reg14 untouched", rg(14), 8'h00);

        tick(20);
        check("R6 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule